// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block gives a host processor access to device configuration space through a pair of fixed I/O ports. The host first loads a 32-bit selector into the address port. A later read or write at the data port is turned into one configuration request toward a bus initiator. The request carries a type-0 formatted address, the host's byte enables, the write data and a one-hot device-select vector decoded from the selector's device field.

The host side is a plain strobed I/O port. A strobe is taken only while `host_ready` is high. Every accepted access ends with a one-cycle `host_done` pulse, and `host_rdata` is valid in that cycle for reads. A forwarded data-port access keeps the host stalled until the initiator acknowledges the request, or until a parameterised timeout expires.

The selector layout is:
- bit 31: enable
- bits 15:11: device
- bits 10:8: function
- bits 7:2: doubleword index

Top module: `cfg_port_xlate`

## Requirements
- R1: A write strobe at host address 0x0CF8 updates the selector, one byte lane per set bit of `host_be`. A read of 0x0CF8 returns the stored value, and its bits 1:0 always read as zero. Both complete with `host_done` in the cycle after the strobe.
- R2: A forwarded data-port read (0x0CFC) issues `req_cmd` 4'b1010, and a forwarded data-port write issues 4'b1011. `req_be` and `req_wdata` carry the host's byte enables and data.
- R3: `req_addr` has bits 1:0 = 00, bits 7:2 = selector bits 7:2, bits 10:8 = selector bits 10:8, and all higher bits zero.
- R4: While a request is pending, `req_idsel` has exactly bit d set, where d is selector bits 15:11, if d < NSLOT. It is all zero when d >= NSLOT and when no request is pending.
- R5: With selector bit 31 clear, a data-port access raises no request and completes in the cycle after the strobe. A read returns 32'hFFFF_FFFF.
- R6: From acceptance of a forwarded access until its completion, `host_ready` is low and `req_valid` stays high with stable fields.
- R7: `host_done` rises in the cycle after the cycle in which `req_valid` and `req_ack` are both high. For a read, `host_rdata` then equals the `req_rdata` sampled with the acknowledge.
- R8: If no acknowledge arrives within TIMEOUT cycles of `req_valid`, the request is withdrawn and the access completes. A read returns 32'hFFFF_FFFF and a write is dropped.
- R9: Strobes at any other host address raise no `host_done`, raise no request and leave the selector unchanged.
- R10: After reset, `host_ready` is high, `req_valid` and `host_done` are low, and the selector reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | HADDR_W | Host I/O address |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe (wins over read) |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read result, valid with host_done |
| host_ready | output | 1 | Block can accept a strobe |
| host_done | output | 1 | Access completed (one-cycle pulse) |
| req_valid | output | 1 | Configuration request pending |
| req_cmd | output | 4 | Configuration command code |
| req_addr | output | 32 | Type-0 formatted address |
| req_be | output | 4 | Byte enables of the request |
| req_wdata | output | 32 | Write data of the request |
| req_idsel | output | NSLOT | One-hot device select |
| req_ack | input | 1 | Initiator acknowledge |
| req_rdata | input | 32 | Read data returned with req_ack |

## Verification
The checker enforces the request's shape on every cycle. This covers the command code, the zero bits of the formatted address, a device select that is at most one-hot, request stability while no acknowledge has arrived, completion right after an acknowledge, and a request lifetime bounded by TIMEOUT. Only the bench scenarios can show the data-dependent behaviour. That includes byte-lane merging into the selector, the exact index, function and device mapping, all-ones returns for disabled or timed-out accesses, and the silence at unrelated addresses.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   localparam logic [15:0] PORT_SELECT = 16'h0CF8;
   localparam logic [15:0] PORT_WINDOW = 16'h0CFC;
   localparam logic [3:0]  CMD_CFG_RD  = 4'b1010;
   localparam logic [3:0]  CMD_CFG_WR  = 4'b1011;
   localparam int          SEL_EN_BIT  = 31;
   localparam int          DEV_LSB     = 11;
   localparam int          DEV_W       = 5;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_WAIT = 1'b1
   } phase_t;
endpackage

// File: rtl/cfgx_sel_reg.sv
module cfgx_sel_reg #(
   parameter int LANES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [LANES-1:0]   be,
   input  logic [LANES*8-1:0] wdata,
   output logic [LANES*8-1:0] q
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_low
         logic [5:0] hi_bits;
         always_ff @(posedge clk) begin
            if (!rst_n)             hi_bits <= '0;
            else if (we && be[0])   hi_bits <= wdata[7:2];
         end
         assign q[7:0] = {hi_bits, 2'b00};
      end else begin : g_full
         logic [7:0] lane_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             lane_q <= '0;
            else if (we && be[g])   lane_q <= wdata[g*8 +: 8];
         end
         assign q[g*8 +: 8] = lane_q;
      end
   end
endmodule

// File: rtl/cfgx_dev_decode.sv
module cfgx_dev_decode #(
   parameter int NSLOT = 16,
   parameter int DEV_W = 5
) (
   input  logic             active,
   input  logic [DEV_W-1:0] dev,
   output logic [NSLOT-1:0] sel
);
   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      assign sel[g] = active && (dev == DEV_W'(g));
   end
endmodule

// File: rtl/cfgx_txn_fsm.sv
module cfgx_txn_fsm
   import cfgx_pkg::*;
#(
   parameter int HADDR_W = 16,
   parameter int TIMEOUT = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic               host_rd,
   input  logic               host_wr,
   input  logic [3:0]         host_be,
   input  logic [31:0]        host_wdata,
   input  logic [31:0]        sel_q,
   output logic               sel_we,
   output logic               host_ready,
   output logic               host_done,
   output logic [31:0]        host_rdata,
   output logic               req_valid,
   output logic [3:0]         req_cmd,
   output logic [3:0]         req_be,
   output logic [31:0]        req_wdata,
   input  logic               req_ack,
   input  logic [31:0]        req_rdata
);
   localparam int CNT_W = $clog2(TIMEOUT + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

   phase_t           phase;
   logic [CNT_W-1:0] wait_cnt;
   logic             take, hit_sel, hit_win;

   always_comb begin
      hit_sel = (host_addr == HADDR_W'(PORT_SELECT));
      hit_win = (host_addr == HADDR_W'(PORT_WINDOW));
      take    = (phase == PH_IDLE) && (host_rd || host_wr);
      sel_we  = take && hit_sel && host_wr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         host_done  <= 1'b0;
         host_rdata <= '0;
         req_cmd    <= '0;
         req_be     <= '0;
         req_wdata  <= '0;
         wait_cnt   <= '0;
      end else begin
         host_done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (take && hit_sel) begin
                  host_done <= 1'b1;
                  if (!host_wr) host_rdata <= sel_q;
               end else if (take && hit_win) begin
                  if (!sel_q[SEL_EN_BIT]) begin
                     host_done <= 1'b1;
                     if (!host_wr) host_rdata <= '1;
                  end else begin
                     phase     <= PH_WAIT;
                     req_cmd   <= host_wr ? CMD_CFG_WR : CMD_CFG_RD;
                     req_be    <= host_be;
                     req_wdata <= host_wdata;
                     wait_cnt  <= '0;
                  end
               end
            end
            PH_WAIT: begin
               if (req_ack) begin
                  phase     <= PH_IDLE;
                  host_done <= 1'b1;
                  if (req_cmd == CMD_CFG_RD) host_rdata <= req_rdata;
               end else if (wait_cnt == CNT_LAST) begin
                  phase     <= PH_IDLE;
                  host_done <= 1'b1;
                  if (req_cmd == CMD_CFG_RD) host_rdata <= '1;
               end else begin
                  wait_cnt <= wait_cnt + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign req_valid  = (phase == PH_WAIT);
   assign host_ready = (phase == PH_IDLE);
endmodule

// File: rtl/cfg_port_xlate.sv
module cfg_port_xlate
   import cfgx_pkg::*;
#(
   parameter int HADDR_W = 16,
   parameter int NSLOT   = 16,
   parameter int TIMEOUT = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic               host_rd,
   input  logic               host_wr,
   input  logic [3:0]         host_be,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   output logic               host_ready,
   output logic               host_done,
   output logic               req_valid,
   output logic [3:0]         req_cmd,
   output logic [31:0]        req_addr,
   output logic [3:0]         req_be,
   output logic [31:0]        req_wdata,
   output logic [NSLOT-1:0]   req_idsel,
   input  logic               req_ack,
   input  logic [31:0]        req_rdata
);
   if (HADDR_W < 12 || HADDR_W > 32) begin : g_bad_aw
      $error("cfg_port_xlate: HADDR_W must lie in 12..32");
   end
   if (NSLOT < 1 || NSLOT > 32) begin : g_bad_slot
      $error("cfg_port_xlate: NSLOT must lie in 1..32");
   end
   if (TIMEOUT < 2) begin : g_bad_to
      $error("cfg_port_xlate: TIMEOUT must be at least 2");
   end

   logic [31:0] sel_q;
   logic        sel_we;

   cfgx_sel_reg #(.LANES(4)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (sel_we),
      .be    (host_be),
      .wdata (host_wdata),
      .q     (sel_q)
   );

   cfgx_txn_fsm #(.HADDR_W(HADDR_W), .TIMEOUT(TIMEOUT)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_addr  (host_addr),
      .host_rd    (host_rd),
      .host_wr    (host_wr),
      .host_be    (host_be),
      .host_wdata (host_wdata),
      .sel_q      (sel_q),
      .sel_we     (sel_we),
      .host_ready (host_ready),
      .host_done  (host_done),
      .host_rdata (host_rdata),
      .req_valid  (req_valid),
      .req_cmd    (req_cmd),
      .req_be     (req_be),
      .req_wdata  (req_wdata),
      .req_ack    (req_ack),
      .req_rdata  (req_rdata)
   );

   cfgx_dev_decode #(.NSLOT(NSLOT), .DEV_W(DEV_W)) u_dec (
      .active (req_valid),
      .dev    (sel_q[DEV_LSB +: DEV_W]),
      .sel    (req_idsel)
   );

   assign req_addr = {21'd0, sel_q[10:8], sel_q[7:2], 2'b00};
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker #(
   parameter int NSLOT   = 16,
   parameter int TIMEOUT = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_ready,
   input logic             host_done,
   input logic             req_valid,
   input logic [3:0]       req_cmd,
   input logic [31:0]      req_addr,
   input logic [NSLOT-1:0] req_idsel,
   input logic             req_ack
);
   localparam int CW = $clog2(TIMEOUT + 2);
   logic [CW-1:0] live_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)         live_cnt <= '0;
      else if (req_valid) live_cnt <= live_cnt + 1'b1;
      else                live_cnt <= '0;
   end

   AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_cmd[3:1] == 3'b101)); // R2
   AST_ADDR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr[1:0] == 2'b00 && req_addr[31:11] == 21'd0)); // R3
   AST_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_idsel)); // R4
   AST_IDSEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (req_idsel == '0)); // R4
   AST_HOST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !host_ready); // R6
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ack) |=> ((req_valid && $stable(req_cmd) && $stable(req_addr)) || host_done)); // R6
   AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ack) |=> (host_done && !req_valid)); // R7
   AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (live_cnt < CW'(TIMEOUT))); // R8
endmodule

bind cfg_port_xlate cfgx_checker #(.NSLOT(NSLOT), .TIMEOUT(TIMEOUT)) u_cfgx_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_ready (host_ready),
   .host_done  (host_done),
   .req_valid  (req_valid),
   .req_cmd    (req_cmd),
   .req_addr   (req_addr),
   .req_idsel  (req_idsel),
   .req_ack    (req_ack)
);

// File: tb/test_cfg_port_xlate.sv
module test_cfg_port_xlate;
   localparam int NSLOT   = 16;
   localparam int TIMEOUT = 12;
   localparam logic [15:0] A_SEL = 16'h0CF8;
   localparam logic [15:0] A_WIN = 16'h0CFC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] host_addr = '0;
   logic host_rd = 1'b0, host_wr = 1'b0;
   logic [3:0] host_be = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic host_ready, host_done, req_valid;
   logic [3:0] req_cmd, req_be;
   logic [31:0] req_addr, req_wdata;
   logic [NSLOT-1:0] req_idsel;
   logic req_ack = 1'b0;
   logic [31:0] req_rdata = '0;

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [31:0] model_sel = '0;

   always #10 clk = ~clk;

   cfg_port_xlate #(.HADDR_W(16), .NSLOT(NSLOT), .TIMEOUT(TIMEOUT)) i_cfg_port_xlate (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
      .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_ready(host_ready), .host_done(host_done), .req_valid(req_valid),
      .req_cmd(req_cmd), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .req_idsel(req_idsel), .req_ack(req_ack), .req_rdata(req_rdata));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] merge_sel(logic [31:0] old, logic [3:0] be, logic [31:0] d);
      logic [31:0] r = old;
      for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8];
      r[1:0] = 2'b00;
      return r;
   endfunction

   function automatic logic [31:0] exp_addr(logic [31:0] s);
      return {21'd0, s[10:8], s[7:2], 2'b00};
   endfunction

   function automatic logic [31:0] exp_idsel(logic [31:0] s);
      logic [31:0] r = '0;
      if (int'(s[15:11]) < NSLOT) r[s[15:11]] = 1'b1;
      return r;
   endfunction

   task automatic access(input bit wr, input logic [15:0] a, input logic [3:0] be,
                         input logic [31:0] wd, input int delay, input logic [31:0] ackd,
                         output logic [31:0] rd, output bit saw, output logic [3:0] cmd,
                         output logic [31:0] raddr, output logic [31:0] rsel,
                         output logic [3:0] rbe, output logic [31:0] rwd,
                         output int lat, output bit stall_bad);
      int n = 0;
      saw = 0; stall_bad = 0; cmd = '0; raddr = '0; rsel = '0; rbe = '0; rwd = '0;
      @(negedge clk);
      host_addr = a; host_be = be; host_wdata = wd; host_wr = wr; host_rd = !wr;
      @(negedge clk);
      host_wr = 0; host_rd = 0;
      while (!host_done && n < 100) begin
         if (req_valid) begin
            saw = 1; cmd = req_cmd; raddr = req_addr; rsel = 32'(req_idsel);
            rbe = req_be; rwd = req_wdata;
            if (host_ready) stall_bad = 1;
         end
         req_ack = req_valid && (n == delay);
         req_rdata = ackd;
         @(negedge clk);
         n++;
      end
      req_ack = 0;
      rd = host_rdata;
      lat = n;
   endtask

   task automatic sel_write(input logic [3:0] be, input logic [31:0] d);
      logic [31:0] rd, ra, rs, rw; logic [3:0] c, rb; bit s, sb; int l;
      access(1, A_SEL, be, d, -1, 0, rd, s, c, ra, rs, rb, rw, l, sb);
      model_sel = merge_sel(model_sel, be, d);
      chk(l == 0 && !s, "R1 select write completes next cycle", 32'(l), 0);
   endtask

   task automatic sel_read_check();
      logic [31:0] rd, ra, rs, rw; logic [3:0] c, rb; bit s, sb; int l;
      access(0, A_SEL, 4'hF, 0, -1, 0, rd, s, c, ra, rs, rb, rw, l, sb);
      chk(rd === model_sel && l == 0, "R1 select readback", rd, model_sel);
   endtask

   task automatic win_access(input bit wr, input logic [3:0] be, input logic [31:0] wd,
                             input int delay, input logic [31:0] ackd);
      logic [31:0] rd, ra, rs, rw; logic [3:0] c, rb; bit s, sb; int l;
      access(wr, A_WIN, be, wd, delay, ackd, rd, s, c, ra, rs, rb, rw, l, sb);
      if (!model_sel[31]) begin
         chk(!s && l == 0, "R5 disabled access raises no request", 32'(s), 0);
         if (!wr) chk(rd === 32'hFFFF_FFFF, "R5 disabled read returns ones", rd, 32'hFFFF_FFFF);
      end else begin
         chk(s && c === (wr ? 4'b1011 : 4'b1010), "R2 command code", 32'(c), wr ? 32'hB : 32'hA);
         chk(ra === exp_addr(model_sel), "R3 formatted address", ra, exp_addr(model_sel));
         chk(rs === exp_idsel(model_sel), "R4 device select", rs, exp_idsel(model_sel));
         chk(!sb, "R6 host stalled while request pending", 32'(sb), 0);
         if (wr) chk(rb === be && rw === wd, "R2 byte enables and write data", rw, wd);
         if (delay >= 0 && delay < TIMEOUT) begin
            chk(l == delay + 1, "R7 completion after acknowledge", 32'(l), 32'(delay + 1));
            if (!wr) chk(rd === ackd, "R7 read data returned", rd, ackd);
         end else begin
            chk(l == TIMEOUT, "R8 timeout latency", 32'(l), 32'(TIMEOUT));
            if (!wr) chk(rd === 32'hFFFF_FFFF, "R8 timeout read returns ones", rd, 32'hFFFF_FFFF);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk(host_ready && !req_valid && !host_done, "R10 reset outputs", {29'd0, host_ready, req_valid, host_done}, 32'h4);
      sel_read_check();

      // R1 full write, bits 1:0 forced to zero
      sel_write(4'hF, 32'h8000_0A07);
      sel_read_check();
      // R2/R3/R4/R7 read with two wait cycles
      win_access(0, 4'hF, 0, 2, 32'h1234_5678);
      // R2 write acknowledged immediately
      win_access(1, 4'b0101, 32'hCAFE_F00D, 0, 0);
      // R8 timeout on read and on write
      win_access(0, 4'hF, 0, -1, 0);
      win_access(1, 4'hF, 32'h5555_AAAA, -1, 0);
      // R1 single lane update
      sel_write(4'b0001, 32'h0000_00FF);
      sel_read_check();
      // R4 device number outside the slot range
      sel_write(4'b0010, 32'h0000_A000);
      win_access(0, 4'hF, 0, 1, 32'h0BAD_0BAD);
      // R5 enable cleared
      sel_write(4'b1000, 32'h0000_0000);
      win_access(0, 4'hF, 0, 0, 32'h1111_1111);
      win_access(1, 4'hF, 32'h2222_2222, 0, 0);

      // R9 unrelated addresses are ignored
      begin
         bit bad = 0;
         @(negedge clk);
         host_addr = 16'h0CF4; host_be = 4'hF; host_wdata = 32'hFFFF_FFFF; host_wr = 1;
         @(negedge clk);
         host_wr = 0; host_addr = 16'h0CFD; host_rd = 1;
         @(negedge clk);
         host_rd = 0;
         repeat (3) begin
            if (host_done || req_valid) bad = 1;
            @(negedge clk);
         end
         chk(!bad, "R9 no response at unrelated address", 32'(bad), 0);
         sel_read_check();
      end

      // randomized mix
      for (int i = 0; i < 80; i++) begin
         int kind = int'($urandom_range(0, 9));
         if (kind < 2) begin
            logic [31:0] d = $urandom();
            d[31] = ($urandom_range(0, 3) != 0);
            sel_write(4'($urandom_range(1, 15)), d);
         end else if (kind < 3) begin
            sel_read_check();
         end else begin
            int dl = ($urandom_range(0, 7) == 0) ? -1 : int'($urandom_range(0, 5));
            win_access(kind[0], 4'($urandom()), $urandom(), dl, $urandom());
         end
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule